// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines into one raw level vector. It drives two outputs from that vector: a normal interrupt request and a fast interrupt request. Each output has its own enable mask, and each is high whenever any raw bit that its mask enables is high. Software changes either mask through a set address and a clear address, so one register write never needs a read-modify-write step. Software reads status, raw levels and masks through a word-indexed register port.

Line 0 doubles as a software interrupt. A register write can raise or lower that raw bit, and an external signal on line 0 can also change it. The bit holds whichever event came last. Controllers can be cascaded: the normal interrupt output of one instance wires into an input line of another. The block does no priority encoding, no vectoring and no edge capture.

Top module: `dual_line_intc`

## Requirements
- R1: One clock edge after a change on lines 31..1, raw bits 31..1 equal those lines. Reads at index 1 and at index 9 both return the whole raw vector.
- R2: A read at index 0 returns raw AND normal-mask. A read at index 2 returns the normal mask.
- R3: A write at index 2 ORs wdata into the normal mask. A write at index 3 clears from it every bit that is 1 in wdata.
- R4: A read at index 8 returns raw AND fast-mask, and a read at index 10 returns the fast mask. A write at index 10 ORs wdata into the fast mask, and a write at index 11 clears every bit that is 1 in wdata.
- R5: A write at index 4 with wdata bit 0 = 1 sets raw bit 0. A write at index 5 with wdata bit 0 = 1 clears it. A write at either index with bit 0 = 0 changes nothing. A read at index 4 returns raw bit 0 in bit 0 and zero in all other bits.
- R6: irq_out is high exactly when raw AND normal-mask is nonzero, and fiq_out is high exactly when raw AND fast-mask is nonzero. Both outputs are registered and change on the same edge as the state they depend on.
- R7: Writes at indices 0, 1, 6, 7, 8, 9 and 12..15 change no state. Reads at indices 3, 5, 6, 7, 11 and 12..15 return zero.
- R8: While rst is high, the raw vector, both masks, both outputs and rdata are cleared to zero.
- R9: Raw bit 0 takes the new level of line 0 on the edge after line 0 changes, and otherwise holds its value. A software set or clear in the same cycle takes priority over a line 0 change.
- R10: rdata is registered. After an edge where rd_en was high, rdata shows the state from before that edge's updates. After an edge where rd_en was low, rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| int_lines | input | 32 | Level interrupt inputs, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one edge after rd_en |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The assertions assume that int_lines and the bus inputs already belong to the clk domain and carry known values at every edge after reset. Nothing in the block synchronises them. The bench keeps to this assumption: it changes every input 1 ns after a rising edge from a single task, and it never drives X. Random stimulus toggles only a few line bits per cycle, so that line 0 transitions can land in the same cycle as a software set or clear of bit 0.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int IDX_W        = 4;

    localparam int IX_NRM_STAT  = 0;
    localparam int IX_RAW_A     = 1;
    localparam int IX_NRM_SET   = 2;
    localparam int IX_NRM_CLR   = 3;
    localparam int IX_SW_SET    = 4;
    localparam int IX_SW_CLR    = 5;
    localparam int IX_FST_STAT  = 8;
    localparam int IX_RAW_B     = 9;
    localparam int IX_FST_SET   = 10;
    localparam int IX_FST_CLR   = 11;

    typedef struct packed {
        logic nrm_set;
        logic nrm_clr;
        logic fst_set;
        logic fst_clr;
        logic sw_set;
        logic sw_clr;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic en,
                                                input logic [31:0] idx,
                                                input logic bit0);
        wr_strobe_t s;
        s = '0;
        if (en) begin
            s.nrm_set = (idx == IX_NRM_SET);
            s.nrm_clr = (idx == IX_NRM_CLR);
            s.fst_set = (idx == IX_FST_SET);
            s.fst_clr = (idx == IX_FST_CLR);
            s.sw_set  = (idx == IX_SW_SET) && bit0;
            s.sw_clr  = (idx == IX_SW_CLR) && bit0;
        end
        return s;
    endfunction

    function automatic logic reads_zero(input logic [31:0] idx);
        case (idx)
            IX_NRM_STAT, IX_RAW_A, IX_NRM_SET, IX_SW_SET,
            IX_FST_STAT, IX_RAW_B, IX_FST_SET: return 1'b0;
            default:                           return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/intc_level_track.sv
module intc_level_track #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    input  logic         sw_set,
    input  logic         sw_clr,
    output logic [N-1:0] raw_q,
    output logic [N-1:0] raw_nxt
);
    logic line0_prev_q;
    logic bit0_nxt;

    // Bit 0: the latest event wins, and a bus write beats a line change.
    always_comb begin
        if (sw_set)
            bit0_nxt = 1'b1;
        else if (sw_clr)
            bit0_nxt = 1'b0;
        else if (lines[0] != line0_prev_q)
            bit0_nxt = lines[0];
        else
            bit0_nxt = raw_q[0];
    end

    assign raw_nxt = {lines[N-1:1], bit0_nxt};

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q        <= '0;
            line0_prev_q <= 1'b0;
        end else begin
            raw_q        <= raw_nxt;
            line0_prev_q <= lines[0];
        end
    end

    assert_follow_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> raw_q[N-1:1] == $past(lines[N-1:1]));
    assert_sw_set_R5: assert property (@(posedge clk) disable iff (rst)
        sw_set |=> raw_q[0]);
    assert_sw_clr_R9: assert property (@(posedge clk) disable iff (rst)
        (sw_clr && !sw_set) |=> !raw_q[0]);

endmodule

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [N-1:0] bits,
    input  logic [N-1:0] raw_q,
    input  logic [N-1:0] raw_nxt,
    output logic [N-1:0] mask_q,
    output logic         out_q
);
    logic [N-1:0] mask_nxt;

    always_comb begin
        mask_nxt = mask_q;
        if (set_we)
            mask_nxt = mask_q | bits;
        else if (clr_we)
            mask_nxt = mask_q & ~bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            out_q  <= 1'b0;
        end else begin
            mask_q <= mask_nxt;
            out_q  <= |(raw_nxt & mask_nxt);
        end
    end

    // Covers both the normal bank (R3) and the fast bank (R4).
    assert_mask_set_R3: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((mask_q & $past(bits)) == $past(bits)));
    assert_mask_clr_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((mask_q & $past(bits)) == '0));
    assert_out_match_R6: assert property (@(posedge clk) disable iff (rst)
        out_q == (|(raw_q & mask_q)));

endmodule

// File: rtl/intc_bus_port.sv
module intc_bus_port
    import intc_pkg::*;
#(
    parameter int N  = 32,
    parameter int AW = IDX_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [AW-1:0] addr,
    input  logic         wr_bit0,
    input  logic [N-1:0] raw_q,
    input  logic [N-1:0] nrm_mask,
    input  logic [N-1:0] fst_mask,
    output wr_strobe_t   stb,
    output logic [N-1:0] rdata
);
    localparam logic [N-1:0] BIT0_ONLY = N'(1);

    logic [31:0]  idx;
    logic [N-1:0] rd_val;

    assign idx = 32'(addr);
    assign stb = decode_write(wr_en, idx, wr_bit0);

    always_comb begin
        case (idx)
            IX_NRM_STAT: rd_val = raw_q & nrm_mask;
            IX_RAW_A:    rd_val = raw_q;
            IX_NRM_SET:  rd_val = nrm_mask;
            IX_SW_SET:   rd_val = raw_q & BIT0_ONLY;
            IX_FST_STAT: rd_val = raw_q & fst_mask;
            IX_RAW_B:    rd_val = raw_q;
            IX_FST_SET:  rd_val = fst_mask;
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_val;
        else
            rdata <= '0;
    end

    assert_hole_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reads_zero(idx)) |=> rdata == '0);

endmodule

// File: rtl/dual_line_intc.sv
module dual_line_intc
    import intc_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int ADDR_W  = IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] int_lines,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [N_LINES-1:0] wdata,
    output logic [N_LINES-1:0] rdata,
    output logic               irq_out,
    output logic               fiq_out
);
    localparam int N_OUTS = 2;

    wr_strobe_t         stb;
    logic [N_LINES-1:0] raw_q;
    logic [N_LINES-1:0] raw_nxt;
    logic [N_LINES-1:0] mask_arr [N_OUTS];
    logic               out_arr  [N_OUTS];
    logic [N_OUTS-1:0]  set_arr;
    logic [N_OUTS-1:0]  clr_arr;

    assign set_arr = {stb.fst_set, stb.nrm_set};
    assign clr_arr = {stb.fst_clr, stb.nrm_clr};

    intc_level_track #(.N(N_LINES)) u_track (
        .clk     (clk),
        .rst     (rst),
        .lines   (int_lines),
        .sw_set  (stb.sw_set),
        .sw_clr  (stb.sw_clr),
        .raw_q   (raw_q),
        .raw_nxt (raw_nxt)
    );

    for (genvar g = 0; g < N_OUTS; g++) begin : g_bank
        intc_mask_bank #(.N(N_LINES)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .set_we  (set_arr[g]),
            .clr_we  (clr_arr[g]),
            .bits    (wdata),
            .raw_q   (raw_q),
            .raw_nxt (raw_nxt),
            .mask_q  (mask_arr[g]),
            .out_q   (out_arr[g])
        );
    end

    intc_bus_port #(.N(N_LINES), .AW(ADDR_W)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wr_bit0  (wdata[0]),
        .raw_q    (raw_q),
        .nrm_mask (mask_arr[0]),
        .fst_mask (mask_arr[1]),
        .stb      (stb),
        .rdata    (rdata)
    );

    assign irq_out = out_arr[0];
    assign fiq_out = out_arr[1];

endmodule

// File: tb/dual_line_intc_bench.sv
module dual_line_intc_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] int_lines;
    logic        wr_en, rd_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq_out, fiq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_raw, m_ie, m_fe;
    logic        m_prev0;

    always #5 clk = ~clk;

    dual_line_intc u_dual_line_intc (
        .clk(clk), .rst(rst), .int_lines(int_lines), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0:        return m_raw & m_ie;
            4'd1, 4'd9:  return m_raw;
            4'd2:        return m_ie;
            4'd4:        return {31'b0, m_raw[0]};
            4'd8:        return m_raw & m_fe;
            4'd10:       return m_fe;
            default:     return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0, 4'd2:         return "R2";
            4'd1, 4'd9:         return "R1";
            4'd4:               return "R5";
            4'd8, 4'd10:        return "R4";
            default:            return "R7";
        endcase
    endfunction

    task automatic step(input logic [31:0] ln, input bit we, input bit re,
                        input logic [3:0] a, input logic [31:0] d,
                        input string t);
        logic [31:0] exp_rd, n_ie, n_fe;
        logic        n0;
        int_lines = ln; wr_en = we; rd_en = re; addr = a; wdata = d;
        exp_rd = re ? model_read(a) : 32'h0;
        if (we && a == 4'd4 && d[0])      n0 = 1'b1;
        else if (we && a == 4'd5 && d[0]) n0 = 1'b0;
        else if (ln[0] != m_prev0)        n0 = ln[0];
        else                              n0 = m_raw[0];
        n_ie = m_ie; n_fe = m_fe;
        if (we && a == 4'd2)  n_ie = m_ie | d;
        if (we && a == 4'd3)  n_ie = m_ie & ~d;
        if (we && a == 4'd10) n_fe = m_fe | d;
        if (we && a == 4'd11) n_fe = m_fe & ~d;
        @(posedge clk); #1;
        m_raw = {ln[31:1], n0}; m_prev0 = ln[0]; m_ie = n_ie; m_fe = n_fe;
        if (re) check(t != "" ? t : tag_of(a), rdata, exp_rd);
        else    check("R10 idle", rdata, 32'h0);
        check("R6 irq", {31'b0, irq_out}, {31'b0, |(m_raw & m_ie)});
        check("R6 fiq", {31'b0, fiq_out}, {31'b0, |(m_raw & m_fe)});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] ln;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1234);
        rst = 1'b1; int_lines = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
        m_raw = '0; m_ie = '0; m_fe = '0; m_prev0 = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R8 irq", {31'b0, irq_out}, 32'h0);
        check("R8 fiq", {31'b0, fiq_out}, 32'h0);
        check("R8 rdata", rdata, 32'h0);
        rst = 1'b0;
        step('0, 0, 1, 4'd1, '0, "R8 raw");
        step('0, 0, 1, 4'd2, '0, "R8 nrm mask");
        step('0, 0, 1, 4'd10, '0, "R8 fst mask");

        // R3 set and clear of the normal mask
        step('0, 1, 0, 4'd2, 32'h0000_00F0, "");
        step('0, 0, 1, 4'd2, '0, "R3 set");
        step('0, 1, 0, 4'd3, 32'h0000_0030, "");
        step('0, 0, 1, 4'd2, '0, "R3 clr");
        // R1 lines followed; R2 status
        step(32'hA5A5_00C0, 0, 0, 4'd0, '0, "");
        step(32'hA5A5_00C0, 0, 1, 4'd1, '0, "R1 raw");
        step(32'hA5A5_00C0, 0, 1, 4'd0, '0, "R2 stat");
        // R4 fast mask
        step(32'hA5A5_00C0, 1, 0, 4'd10, 32'h0100_0000, "");
        step(32'hA5A5_00C0, 0, 1, 4'd8, '0, "R4 stat");
        step(32'hA5A5_00C0, 1, 0, 4'd11, 32'hFFFF_FFFF, "");
        step(32'hA5A5_00C0, 0, 1, 4'd10, '0, "R4 clr");
        // R7 ignored writes, zero reads
        step(32'hA5A5_00C0, 1, 0, 4'd0, 32'hFFFF_FFFF, "");
        step(32'hA5A5_00C0, 1, 0, 4'd9, 32'hFFFF_FFFF, "");
        step(32'hA5A5_00C0, 1, 0, 4'd13, 32'hFFFF_FFFF, "");
        step(32'hA5A5_00C0, 0, 1, 4'd2, '0, "R7 mask kept");
        step(32'hA5A5_00C0, 0, 1, 4'd10, '0, "R7 fmask kept");
        step(32'hA5A5_00C0, 0, 1, 4'd3, '0, "R7 hole");
        step(32'hA5A5_00C0, 0, 1, 4'd5, '0, "R7 hole");
        step(32'hA5A5_00C0, 0, 1, 4'd11, '0, "R7 hole");
        step(32'hA5A5_00C0, 0, 1, 4'd14, '0, "R7 hole");
        // R5 software bit
        step('0, 1, 0, 4'd4, 32'h1, "");
        step('0, 0, 1, 4'd4, '0, "R5 set");
        step('0, 1, 0, 4'd5, 32'hFFFF_FFFE, "");
        step('0, 0, 1, 4'd4, '0, "R5 bit0 zero");
        step('0, 1, 0, 4'd5, 32'h1, "");
        step('0, 0, 1, 4'd4, '0, "R5 clr");
        // R9 arbitration on bit 0
        step(32'h1, 1, 0, 4'd5, 32'h1, "");
        step(32'h1, 0, 1, 4'd4, '0, "R9 write wins");
        step(32'h1, 0, 1, 4'd4, '0, "R9 hold");
        step('0, 0, 1, 4'd4, '0, "R9 hold");
        step('0, 0, 1, 4'd4, '0, "R9 fall");
        step(32'h1, 0, 0, 4'd0, '0, "");
        step(32'h1, 0, 1, 4'd4, '0, "R9 rise");
        // R10 read in write cycle shows old state
        step(32'h1, 1, 1, 4'd2, 32'h0000_0001, "R10 old");
        step(32'h1, 0, 1, 4'd2, '0, "R10 new");

        // Random mix
        ln = 32'h0;
        for (int i = 0; i < 3000; i++) begin
            bit we, re;
            logic [3:0] a;
            logic [31:0] d;
            ln = ln ^ (32'h1 << ($urandom % 32)) ^ (($urandom % 4 == 0) ? 32'h1 : 32'h0);
            a  = 4'($urandom % 16);
            we = ($urandom % 2) == 1;
            re = !we && (($urandom % 3) != 0);
            d  = $urandom;
            if ($urandom % 4 == 0) d = d & 32'h0000_0001;
            step(ln, we, re, a, d, "");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule